// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block is a bus master. It moves one operand of one to four bytes across a 16-bit external data bus. It does not know the width of the target port in advance. Each bus cycle starts on the assumption that the port is 16 bits wide. The slave's acknowledge code then says whether the port is really 16 or 8 bits wide. From that answer the sequencer works out how many bytes the cycle moved, and it issues further cycles until the whole operand has gone. Each further cycle carries a higher address and a lower remaining-size code.

A request gives a direction, a size code, a byte address and, for a write, the operand. The operand is right-justified, so its most significant byte is moved first. Write bytes are placed on fixed byte lanes chosen by address bit 0. Read bytes are taken from fixed lanes chosen by the port width and address bit 0, and are packed back into a right-justified 32-bit result. That result is presented with a one-clock done strobe. A word or long-word request at an odd address is refused with a one-clock address-error strobe, and no bus cycle is run.

Top module: `dbs_sequencer`

## Requirements
- R1: After reset, bus_cyc, busy, done and addr_err are all 0.
- R2: During each bus cycle, bus_siz gives the number of operand bytes still to move: 2'b01 for one, 2'b10 for two, 2'b11 for three and 2'b00 for four. The request's req_size uses the same code.
- R3: The first cycle drives the request address. Each later cycle drives the previous address plus the number of bytes the previous cycle moved.
- R4: bus_ack_n is active low. The value 2'b01 or 2'b00 means a 16-bit port, and 2'b10 means an 8-bit port. While bus_ack_n is 2'b11 the cycle is extended, and bus_addr, bus_siz and bus_dout hold steady.
- R5: An 8-bit port moves one byte per cycle. A 16-bit port moves two bytes when the address is even and two or more bytes remain; otherwise it moves one. So a long word takes two cycles to an even 16-bit port and four cycles to an 8-bit port.
- R6: For a write at an even address, the next operand byte is on bus_dout[15:8] and the byte after it is on bus_dout[7:0]. At an odd address, the next operand byte is on both lanes.
- R7: A read takes a byte from bus_din[15:8] for an 8-bit port. For a 16-bit port at an odd address it takes bus_din[7:0]. For a 16-bit port at an even address it takes [15:8] first, then [7:0].
- R8: One clock after the acknowledge that completes the operand, done is 1 for exactly one clock. At that time rdata holds the read operand right-justified, with the first byte moved as the most significant byte.
- R9: A request with size 2'b10 or 2'b00 and address bit 0 set makes addr_err 1 for one clock and starts no bus cycle. Byte and three-byte requests are accepted at any address.
- R10: While busy is 1, req_valid is ignored: it changes no bus output, and no cycle or error follows the done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code (R2 encoding) |
| req_addr | input | ADDR_W | Byte address of the first operand byte |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | A transfer is in progress |
| addr_err | output | 1 | One-clock strobe for a misaligned word or long word |
| done | output | 1 | One-clock strobe when the operand is complete |
| rdata | output | 32 | Assembled read operand, valid with done |
| bus_cyc | output | 1 | A bus cycle is active |
| bus_we | output | 1 | Direction of the active cycle |
| bus_addr | output | ADDR_W | Byte address of the active cycle |
| bus_siz | output | 2 | Bytes still to move, R2 encoding |
| bus_dout | output | 16 | Write data lanes |
| bus_ack_n | input | 2 | Active-low acknowledge and port-width code |
| bus_din | input | 16 | Read data lanes |

## Verification
The hardest cases to reach are a three-byte operand that starts at an odd address on a 16-bit port, and a long word on an 8-bit port. In both, the byte count per cycle changes partway through the operand and the lane choice moves with address bit 0. The bench reaches them directly. It also runs random transfers in which the slave model picks the port width, the acknowledge code (including the 2'b00 form) and a wait of zero to three clocks for each transaction. The slave serves reads from an address-derived byte pattern and logs write lanes, so every routed byte is compared against its own address.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned OPND_W = 32;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_TRI  = 2'b11;

  typedef enum logic {ST_IDLE, ST_CYC} seq_state_e;

  function automatic logic ack_present(input logic [1:0] ack_n);
    return ack_n != 2'b11;
  endfunction

  function automatic logic ack_wide(input logic [1:0] ack_n);
    return ~ack_n[1];
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    return (code == SZ_LONG) ? 3'd4 : {1'b0, code};
  endfunction
endpackage

// File: rtl/dbs_step.sv
module dbs_step (
  input  logic [2:0] rem,
  input  logic       addr0,
  input  logic       wide,
  output logic [2:0] moved
);
  always_comb begin
    if (wide && !addr0 && (rem >= 3'd2)) moved = 3'd2;
    else                                 moved = 3'd1;
  end
endmodule

// File: rtl/dbs_wlane.sv
module dbs_wlane (
  input  logic [15:0] head,
  input  logic        addr0,
  output logic [15:0] dout
);
  always_comb begin
    if (addr0) dout = {head[15:8], head[15:8]};
    else       dout = head;
  end
endmodule

// File: rtl/dbs_rlane.sv
module dbs_rlane (
  input  logic [15:0] din,
  input  logic        wide,
  input  logic        addr0,
  input  logic [2:0]  moved,
  input  logic [31:0] acc,
  output logic [31:0] acc_nxt
);
  logic [7:0] one_byte;

  always_comb begin
    one_byte = (wide && addr0) ? din[7:0] : din[15:8];
    if (moved == 3'd2) acc_nxt = {acc[15:0], din};
    else               acc_nxt = {acc[23:0], one_byte};
  end
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              addr_err,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              bus_cyc,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [15:0]       bus_dout,
  input  logic [1:0]        bus_ack_n,
  input  logic [15:0]       bus_din
);
  import dbs_pkg::*;

  localparam int unsigned SYNC_STAGES = 2;

  // reset: asserted at once, removed on a clock edge
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  seq_state_e        st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [2:0]        rem_q, rem_n;
  logic              we_q, we_n;
  logic [31:0]       wsh_q, wsh_n;
  logic [31:0]       acc_q, acc_n;
  logic              done_q, done_n;
  logic              err_q, err_n;

  logic [2:0]  moved;
  logic [31:0] acc_step;
  logic        seen, wide, start, misal, load_en;
  logic [2:0]  req_nb;
  logic [5:0]  lead_sh;

  assign seen  = ack_present(bus_ack_n);
  assign wide  = ack_wide(bus_ack_n);
  assign misal = req_addr[0] && ((req_size == SZ_WORD) || (req_size == SZ_LONG));
  assign start = (st_q == ST_IDLE) && req_valid;
  assign req_nb  = size_bytes(req_size);
  assign lead_sh = {(3'd4 - req_nb), 3'b000};

  dbs_step u_step (
    .rem   (rem_q),
    .addr0 (addr_q[0]),
    .wide  (wide),
    .moved (moved)
  );

  dbs_rlane u_rlane (
    .din     (bus_din),
    .wide    (wide),
    .addr0   (addr_q[0]),
    .moved   (moved),
    .acc     (acc_q),
    .acc_nxt (acc_step)
  );

  dbs_wlane u_wlane (
    .head  (wsh_q[31:16]),
    .addr0 (addr_q[0]),
    .dout  (bus_dout)
  );

  // next-state logic
  always_comb begin
    st_n    = st_q;
    addr_n  = addr_q;
    rem_n   = rem_q;
    we_n    = we_q;
    wsh_n   = wsh_q;
    acc_n   = acc_q;
    done_n  = 1'b0;
    err_n   = 1'b0;
    load_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (misal) begin
            err_n = 1'b1;
          end else begin
            load_en = 1'b1;
            st_n    = ST_CYC;
            addr_n  = req_addr;
            rem_n   = req_nb;
            we_n    = req_write;
            wsh_n   = req_wdata << lead_sh;
            acc_n   = '0;
          end
        end
      end
      ST_CYC: begin
        if (seen) begin
          load_en = 1'b1;
          acc_n   = acc_step;
          wsh_n   = wsh_q << {moved, 3'b000};
          addr_n  = addr_q + ADDR_W'(moved);
          rem_n   = rem_q - moved;
          if (rem_q == moved) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  // datapath registers, clock-enabled
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      we_q   <= 1'b0;
      wsh_q  <= '0;
      acc_q  <= '0;
    end else if (load_en) begin
      addr_q <= addr_n;
      rem_q  <= rem_n;
      we_q   <= we_n;
      wsh_q  <= wsh_n;
      acc_q  <= acc_n;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign bus_cyc  = (st_q == ST_CYC);
  assign bus_we   = we_q;
  assign bus_addr = addr_q;
  assign bus_siz  = rem_q[1:0];
  assign rdata    = acc_q;
  assign done     = done_q;
  assign addr_err = err_q;
endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_err,
  input logic              done,
  input logic              bus_cyc,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic [15:0]       bus_dout,
  input logic [1:0]        bus_ack_n
);
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack_n == 2'b11) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout))); // R4

  AST_NARROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack_n == 2'b10 && bus_siz != 2'b01) |=>
      (bus_cyc && bus_addr == $past(bus_addr) + 1'b1 && bus_siz == $past(bus_siz) - 2'b01)); // R5

  AST_ODD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_we && bus_addr[0]) |-> (bus_dout[15:8] == bus_dout[7:0])); // R6

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!bus_cyc && !done)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_cyc && bus_ack_n != 2'b11)); // R8
endmodule

bind dbs_sequencer dbs_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_err  (addr_err),
  .done      (done),
  .bus_cyc   (bus_cyc),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_siz   (bus_siz),
  .bus_dout  (bus_dout),
  .bus_ack_n (bus_ack_n)
);

// File: tb/sim_dbs_sequencer.sv
module sim_dbs_sequencer;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 24;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          busy, addr_err, done;
  logic [31:0]   rdata;
  logic          bus_cyc, bus_we;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [15:0]   bus_dout;
  logic [1:0]    bus_ack_n;
  logic [15:0]   bus_din;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  dbs_sequencer #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .addr_err(addr_err), .done(done), .rdata(rdata),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_dout(bus_dout), .bus_ack_n(bus_ack_n), .bus_din(bus_din)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic int nbytes_of(input logic [1:0] code);
    return (code == 2'b00) ? 4 : int'(code);
  endfunction

  function automatic logic [7:0] op_byte(input logic [31:0] w, input int n, input int k);
    return w[(n - 1 - k) * 8 +: 8];
  endfunction

  function automatic int cycles_of(input int n, input bit a0, input bit p8);
    if (p8) return n;
    if (a0) return 1 + (n / 2);
    return (n + 1) / 2;
  endfunction

  // one transaction with the bench acting as slave
  task automatic do_txn(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] wd, input bit p8, input bit ack00,
                        input int max_wait, input bit ign, input int exp_cyc);
    int n, rem, k, cyc, moved;
    logic [AW-1:0] ea;
    logic [31:0] exp_r;
    n = nbytes_of(sz);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (ign) begin
      req_write = ~wr; req_size = 2'b10; req_addr = a + 24'h101; req_wdata = ~wd;
    end else req_valid = 1'b0;
    ea = a; rem = n; k = 0; cyc = 0;
    while (rem > 0) begin
      int w;
      w = $urandom_range(0, max_wait);
      chk(bus_cyc === 1'b1, "R3 bus_cyc", {31'd0, bus_cyc}, 32'd1);
      chk(bus_addr === ea, "R3 cycle address", {8'd0, bus_addr}, {8'd0, ea});
      chk(bus_siz === rem[1:0], "R2 size code", {30'd0, bus_siz}, {30'd0, rem[1:0]});
      chk(bus_we === wr, "R3 direction", {31'd0, bus_we}, {31'd0, wr});
      for (int i = 0; i < w; i++) begin
        bus_ack_n = 2'b11;
        @(negedge clk);
        chk(bus_cyc === 1'b1 && bus_addr === ea && bus_siz === rem[1:0], "R4 wait hold",
            {8'd0, bus_addr}, {8'd0, ea});
      end
      if (p8) moved = 1;
      else if (!ea[0] && rem >= 2) moved = 2;
      else moved = 1;
      if (p8) bus_ack_n = 2'b10;
      else bus_ack_n = ack00 ? 2'b00 : 2'b01;
      if (p8) bus_din = {mem_byte(ea), 8'($urandom)};
      else if (ea[0]) bus_din = {mem_byte(ea - 1'b1), mem_byte(ea)};
      else bus_din = {mem_byte(ea), mem_byte(ea + 1'b1)};
      if (wr) begin
        chk(bus_dout[15:8] === op_byte(wd, n, k), "R6 upper lane",
            {24'd0, bus_dout[15:8]}, {24'd0, op_byte(wd, n, k)});
        if (ea[0])
          chk(bus_dout[7:0] === op_byte(wd, n, k), "R6 odd copy lane",
              {24'd0, bus_dout[7:0]}, {24'd0, op_byte(wd, n, k)});
        else if (rem >= 2)
          chk(bus_dout[7:0] === op_byte(wd, n, k + 1), "R6 lower lane",
              {24'd0, bus_dout[7:0]}, {24'd0, op_byte(wd, n, k + 1)});
      end
      if (ign && rem == moved) req_valid = 1'b0;
      @(negedge clk);
      bus_ack_n = 2'b11;
      bus_din = 16'($urandom);
      rem -= moved; k += moved; ea += AW'(moved); cyc++;
    end
    exp_r = '0;
    for (int j = 0; j < n; j++) exp_r = (exp_r << 8) | {24'd0, mem_byte(a + AW'(j))};
    chk(done === 1'b1 && busy === 1'b0, "R8 done strobe", {31'd0, done}, 32'd1);
    chk(cyc == exp_cyc, "R5 cycle count", cyc, exp_cyc);
    if (!wr) chk(rdata === exp_r, "R7 R8 read result", rdata, exp_r);
    @(negedge clk);
    chk(done === 1'b0 && bus_cyc === 1'b0 && addr_err === 1'b0, "R10 R8 quiet after done",
        {29'd0, done, bus_cyc, addr_err}, 32'd0);
  endtask

  task automatic do_err(input logic [1:0] sz, input logic [AW-1:0] a);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = a; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(addr_err === 1'b1 && bus_cyc === 1'b0, "R9 error strobe",
        {30'd0, addr_err, bus_cyc}, 32'd2);
    @(negedge clk);
    chk(addr_err === 1'b0 && bus_cyc === 1'b0 && busy === 1'b0, "R9 no cycle",
        {29'd0, addr_err, bus_cyc, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d2b));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b01;
    req_addr = '0; req_wdata = '0; bus_ack_n = 2'b11; bus_din = '0;
    repeat (3) @(negedge clk);
    chk(bus_cyc === 1'b0 && busy === 1'b0 && done === 1'b0 && addr_err === 1'b0, "R1 reset",
        {28'd0, bus_cyc, busy, done, addr_err}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_cyc === 1'b0 && busy === 1'b0, "R1 after release", {30'd0, bus_cyc, busy}, 32'd0);

    do_txn(0, 2'b00, 24'h001000, 32'h0, 0, 0, 0, 0, 2);                // R5 long to 16-bit
    do_txn(0, 2'b00, 24'h002004, 32'h0, 1, 0, 2, 0, 4);                // R5 long to 8-bit
    do_txn(1, 2'b00, 24'h003000, 32'hA1B2C3D4, 0, 0, 1, 0, 2);         // R6 even lanes
    do_txn(1, 2'b10, 24'h004010, 32'h00005E6F, 1, 0, 0, 0, 2);         // R6 8-bit word
    do_txn(1, 2'b01, 24'h005001, 32'h0000009C, 0, 0, 0, 0, 1);         // R6 odd copy
    do_txn(0, 2'b01, 24'h006003, 32'h0, 0, 0, 0, 0, 1);                // R7 odd byte low lane
    do_txn(0, 2'b11, 24'h007005, 32'h0, 0, 0, 0, 0, 2);                // R5 three-byte odd
    do_txn(0, 2'b11, 24'h007008, 32'h0, 0, 1, 0, 0, 2);                // R4 ack 00 as 16-bit
    do_txn(1, 2'b11, 24'h008009, 32'h00123456, 1, 0, 3, 0, 3);         // R5 three-byte 8-bit
    do_err(2'b10, 24'h009001);                                          // R9 odd word
    do_err(2'b00, 24'h009003);                                          // R9 odd long
    do_txn(0, 2'b00, 24'h00A000, 32'h0, 1, 0, 1, 1, 4);                // R10 ignored request
    do_txn(1, 2'b10, 24'h00B002, 32'h0000BEEF, 0, 0, 2, 1, 1);         // R10 ignored request

    for (int t = 0; t < 300; t++) begin
      logic [1:0] sz;
      logic [AW-1:0] a;
      bit p8;
      sz = 2'($urandom);
      a  = AW'($urandom);
      if ((sz == 2'b10 || sz == 2'b00)) a[0] = 1'b0;
      p8 = 1'($urandom);
      do_txn(1'($urandom), sz, a, $urandom, p8, 1'($urandom), 3, 1'($urandom_range(0, 3) == 0),
             cycles_of(nbytes_of(sz), a[0], p8));
    end
    finish_run();
  end
endmodule